// File: doc/BRIEF.md
# Interrupt Enable and Acceptance Controller

This block keeps the processor's interrupt-enable flag and decides, clock by clock, whether a level-sensitive interrupt request is taken. The instruction decoder sends one-clock strobes to turn interrupts on or off. The sequencer marks the last clock of each instruction and reports when the core is halted. The bus arbiter reports when another master holds the buses. When a request is accepted, the block raises a one-clock accept pulse that tells the fetch unit to run an interrupt-acknowledge opcode fetch. If the core was halted, a wake pulse comes with it so that the halt state exits into that fetch.

After an acceptance, the block keeps a pending mark until the fetch unit reports the first clock (T1) of the acknowledge fetch. On that clock the enable flag clears, so no second interrupt can nest. The request line passes through a configurable number of synchronizer stages before it is examined.

Top module: `intr_accept_ctl`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, `inte`, `accept` and `wake` read 0. The synchronizer stages and the pending mark are also cleared by `rst`.
- R2: A clock with `ei_stb` high and `di_stb` low sets the enable flag. `inte` shows the new value from the following clock onward.
- R3: A clock with `di_stb` high clears the enable flag in the following clock. This holds even when `ei_stb` is high in the same clock, because disable wins.
- R4: The block accepts a request on a clock edge when all of these hold: the synchronized request is 1, the flag is set, `instr_done` or `halted` is 1, `bus_held` is 0, and no acceptance is pending. `accept` is then 1 for exactly the one following clock.
- R5: A request seen while the enable flag is clear leaves `accept` at 0.
- R6: A request seen while `bus_held` is 1 leaves `accept` at 0.
- R7: A request seen while both `instr_done` and `halted` are 0 leaves `accept` at 0.
- R8: The block does not use `irq_req` directly. It uses the value that `irq_req` had IRQ_SYNC clock edges earlier, where 0 means the current value.
- R9: After an acceptance, no further acceptance occurs until a clock with `ack_t1` high. On that clock the enable flag clears, so `inte` reads 0 from the next clock.
- R10: `ack_t1` high while no acceptance is pending has no effect on `inte`.
- R11: `wake` is 1 only in the same clock as `accept`, and only if `halted` was 1 when the request was taken.
- R12: If `irq_req` drops after the accept pulse, the pending acceptance still clears the flag at the next `ack_t1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Level-sensitive interrupt request |
| ei_stb | input | 1 | Enable-interrupts strobe from the decoder |
| di_stb | input | 1 | Disable-interrupts strobe from the decoder |
| instr_done | input | 1 | Last clock of the current instruction |
| halted | input | 1 | Core is in the halt state |
| bus_held | input | 1 | Buses are granted to another master |
| ack_t1 | input | 1 | First clock of the interrupt-acknowledge fetch |
| inte | output | 1 | Current value of the interrupt-enable flag |
| accept | output | 1 | One-clock request to start the acknowledge fetch |
| wake | output | 1 | One-clock pulse that leaves the halt state |

## Verification
The bench builds the block with IRQ_SYNC = 2. This puts the two-edge lag between `irq_req` and the acceptance decision within reach, together with the case where the request is withdrawn while still inside the synchronizer. With that lag, a request can disappear at the input while a stale copy is still accepted. It can also arrive too late to be seen at an instruction boundary. The randomised run, with rare strobes and frequent instruction ends, meets both situations many times, and also meets strobes that land on the clock of a pending T1.

// File: rtl/intr_accept_pkg.sv
package intr_accept_pkg;

   typedef enum logic [1:0] {
      IE_KEEP = 2'd0,
      IE_SET  = 2'd1,
      IE_CLR  = 2'd2
   } ie_cmd_e;

   // clear requests dominate set requests
   function automatic ie_cmd_e ie_decode(input logic set_req, input logic clr_req);
      if (clr_req)
         return IE_CLR;
      else if (set_req)
         return IE_SET;
      else
         return IE_KEEP;
   endfunction

   localparam int unsigned IRQ_SYNC_MAX = 4;

endpackage

// File: rtl/intr_irq_sync.sv
module intr_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
               if (rst)
                  chain_q <= '0;
               else
                  chain_q <= d_in;
            end
         end else begin : g_many
            always_ff @(posedge clk) begin
               if (rst)
                  chain_q <= '0;
               else
                  chain_q <= {chain_q[STAGES-2:0], d_in};
            end
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/intr_ie_flag.sv
module intr_ie_flag
   import intr_accept_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic set_req,
   input  logic clr_req,
   output logic ie
);
   ie_cmd_e cmd;
   logic    ie_q;

   always_comb cmd = ie_decode(set_req, clr_req);

   always_ff @(posedge clk) begin
      if (rst)
         ie_q <= 1'b0;
      else begin
         unique case (cmd)
            IE_SET:  ie_q <= 1'b1;
            IE_CLR:  ie_q <= 1'b0;
            default: ie_q <= ie_q;
         endcase
      end
   end

   assign ie = ie_q;
endmodule

// File: rtl/intr_take_ctl.sv
module intr_take_ctl (
   input  logic clk,
   input  logic rst,
   input  logic irq_seen,
   input  logic ie,
   input  logic instr_done,
   input  logic halted,
   input  logic bus_held,
   input  logic ack_t1,
   output logic accept,
   output logic wake,
   output logic pending,
   output logic ie_drop
);
   logic window;
   logic take;
   logic acc_q, wake_q, pend_q;

   always_comb begin
      window  = instr_done | halted;
      take    = irq_seen & ie & window & ~bus_held & ~pend_q;
      ie_drop = ack_t1 & pend_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= 1'b0;
         wake_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         acc_q  <= take;
         wake_q <= take & halted;
         pend_q <= (pend_q & ~ack_t1) | take;
      end
   end

   assign accept  = acc_q;
   assign wake    = wake_q;
   assign pending = pend_q;
endmodule

// File: rtl/intr_accept_ctl.sv
module intr_accept_ctl
   import intr_accept_pkg::*;
#(
   parameter int unsigned IRQ_SYNC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic irq_req,
   input  logic ei_stb,
   input  logic di_stb,
   input  logic instr_done,
   input  logic halted,
   input  logic bus_held,
   input  logic ack_t1,
   output logic inte,
   output logic accept,
   output logic wake
);
   generate
      if (IRQ_SYNC > IRQ_SYNC_MAX) begin : g_bad_sync
         $error("intr_accept_ctl: IRQ_SYNC exceeds IRQ_SYNC_MAX");
      end
   endgenerate

   logic irq_seen;
   logic ie;
   logic pending;
   logic ie_drop;

   intr_irq_sync #(.STAGES(IRQ_SYNC)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d_in  (irq_req),
      .d_out (irq_seen)
   );

   intr_ie_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_req (ei_stb),
      .clr_req (di_stb | ie_drop),
      .ie      (ie)
   );

   intr_take_ctl u_take (
      .clk        (clk),
      .rst        (rst),
      .irq_seen   (irq_seen),
      .ie         (ie),
      .instr_done (instr_done),
      .halted     (halted),
      .bus_held   (bus_held),
      .ack_t1     (ack_t1),
      .accept     (accept),
      .wake       (wake),
      .pending    (pending),
      .ie_drop    (ie_drop)
   );

   assign inte = ie;
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk (
   input logic clk,
   input logic rst,
   input logic ei_stb,
   input logic di_stb,
   input logic bus_held,
   input logic halted,
   input logic ack_t1,
   input logic pending,
   input logic inte,
   input logic accept,
   input logic wake
);
   p_di_clears_r3: assert property (@(posedge clk) disable iff (rst)
      di_stb |=> !inte);

   p_ei_sets_r2: assert property (@(posedge clk) disable iff (rst)
      (ei_stb && !di_stb && !ack_t1) |=> inte);

   p_one_clock_r4: assert property (@(posedge clk) disable iff (rst)
      accept |=> !accept);

   p_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
      accept |-> $past(inte));

   p_not_held_r6: assert property (@(posedge clk) disable iff (rst)
      accept |-> $past(!bus_held));

   p_pend_blocks_r9: assert property (@(posedge clk) disable iff (rst)
      (pending && !ack_t1) |=> !accept);

   p_t1_clears_r9: assert property (@(posedge clk) disable iff (rst)
      (pending && ack_t1) |=> !inte);

   p_wake_with_acc_r11: assert property (@(posedge clk) disable iff (rst)
      wake |-> (accept && $past(halted)));
endmodule

bind intr_accept_ctl intr_accept_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .ei_stb   (ei_stb),
   .di_stb   (di_stb),
   .bus_held (bus_held),
   .halted   (halted),
   .ack_t1   (ack_t1),
   .pending  (pending),
   .inte     (inte),
   .accept   (accept),
   .wake     (wake)
);

// File: tb/intr_accept_ctl_bench.sv
module intr_accept_ctl_bench;
   localparam int unsigned TB_SYNC = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic irq_req = 1'b0, ei_stb = 1'b0, di_stb = 1'b0, instr_done = 1'b0;
   logic halted = 1'b0, bus_held = 1'b0, ack_t1 = 1'b0;
   logic inte, accept, wake;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   // reference state
   logic m_ie = 0, m_pend = 0, m_acc = 0, m_wake = 0, m_s1 = 0, m_s2 = 0;

   always #2 clk = ~clk;

   intr_accept_ctl #(.IRQ_SYNC(TB_SYNC)) u_intr_accept_ctl (
      .clk(clk), .rst(rst), .irq_req(irq_req), .ei_stb(ei_stb), .di_stb(di_stb),
      .instr_done(instr_done), .halted(halted), .bus_held(bus_held), .ack_t1(ack_t1),
      .inte(inte), .accept(accept), .wake(wake)
   );

   task automatic chk(input string tag, input string what, input logic got, input logic exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
      end
   endtask

   function automatic logic ie_next(input logic ie, input logic pend, input logic ei,
                                    input logic di, input logic t1);
      if (di || (t1 && pend)) return 1'b0;
      if (ei) return 1'b1;
      return ie;
   endfunction

   function automatic logic take_now(input logic seen, input logic ie, input logic pend,
                                     input logic eoi, input logic hlt, input logic hold);
      return seen & ie & (eoi | hlt) & ~hold & ~pend;
   endfunction

   task automatic step(input string tag, input logic r, input logic i, input logic ei,
                       input logic di, input logic eoi, input logic hlt, input logic hold,
                       input logic t1);
      logic ok, n_ie, n_pend;
      rst = r; irq_req = i; ei_stb = ei; di_stb = di; instr_done = eoi;
      halted = hlt; bus_held = hold; ack_t1 = t1;
      ok     = take_now(m_s2, m_ie, m_pend, eoi, hlt, hold);
      n_ie   = ie_next(m_ie, m_pend, ei, di, t1);
      n_pend = (m_pend & ~t1) | ok;
      @(posedge clk);
      #1;
      if (r) begin
         m_ie = 0; m_pend = 0; m_acc = 0; m_wake = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         m_ie = n_ie; m_pend = n_pend; m_acc = ok; m_wake = ok & hlt;
         m_s2 = m_s1; m_s1 = i;
      end
      chk(tag, "inte", inte, m_ie);
      chk(tag, "accept", accept, m_acc);
      chk(tag, "wake", wake, m_wake);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R1: reset state
      step("R1", 1, 1, 1, 0, 1, 0, 0, 0);
      step("R1", 1, 1, 1, 0, 1, 0, 0, 0);
      step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
      // R5: request with flag clear
      for (int k = 0; k < 4; k++) step("R5", 0, 1, 0, 0, 1, 0, 0, 0);
      // R2: enable
      step("R2", 0, 0, 1, 0, 0, 0, 0, 0);
      // R3: both strobes, disable wins
      step("R3", 0, 0, 1, 1, 0, 0, 0, 0);
      step("R3", 0, 0, 1, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 1, 0, 0, 0, 0);
      step("R2", 0, 0, 1, 0, 0, 0, 0, 0);
      // R10: stray T1
      step("R10", 0, 0, 0, 0, 0, 0, 0, 1);
      // R6: held bus blocks
      for (int k = 0; k < 4; k++) step("R6", 0, 1, 0, 0, 1, 0, 1, 0);
      // R7: no boundary, no halt
      for (int k = 0; k < 3; k++) step("R7", 0, 1, 0, 0, 0, 0, 0, 0);
      // R4 / R8: boundary; request already through the synchronizer
      step("R4", 0, 0, 0, 0, 1, 0, 0, 0);
      step("R4", 0, 0, 0, 0, 0, 0, 0, 0);
      // R9: pending blocks, INT gone (R12), then T1 clears flag
      for (int k = 0; k < 3; k++) step("R12", 0, 0, 0, 0, 1, 0, 0, 0);
      step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
      step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
      // R8: fresh request needs two edges
      step("R8", 0, 0, 1, 0, 0, 0, 0, 0);
      step("R8", 0, 1, 0, 0, 1, 0, 0, 0);
      step("R8", 0, 1, 0, 0, 1, 0, 0, 0);
      step("R8", 0, 1, 0, 0, 1, 0, 0, 0);
      step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
      // R11: wake from halt
      step("R11", 0, 0, 1, 0, 0, 1, 0, 0);
      step("R11", 0, 1, 0, 0, 0, 1, 0, 0);
      step("R11", 0, 1, 0, 0, 0, 1, 0, 0);
      step("R11", 0, 1, 0, 0, 0, 1, 0, 0);
      step("R11", 0, 0, 0, 0, 0, 0, 0, 1);
      // random mix
      for (int n = 0; n < 4000; n++) begin
         step("R4", ($urandom % 500) == 0, ($urandom % 3) != 0, ($urandom % 6) == 0,
              ($urandom % 12) == 0, ($urandom % 3) == 0, ($urandom % 8) == 0,
              ($urandom % 7) == 0, ($urandom % 5) == 0);
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule